// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block holds the shared interrupt-control word of a seven-channel DMA controller and turns channel completions into one interrupt request for the system interrupt controller. Software programs per-channel enables, a master enable and a force bit through a register-bus port at offset 0xF4. It acknowledges completions by writing ones to the flag bits. Each DMA engine reports the end of a transfer with a one-cycle done pulse.

A master flag in the top bit summarises the whole word. It is recomputed whenever the word changes, either through a register write or through a flag being set by a done pulse. The block emits a single-cycle interrupt pulse only on the update that takes the master flag from clear to set. Software therefore has to drop the master flag, by clearing flags or the force bit, before another interrupt can be raised.

Top module: `dma_irq_ctl`

## Requirements
- R1: While reset is held, and for the cycles after its release, the word reads 0x00000000 and the interrupt pulse is low.
- R2: A write at offset 0xF4 loads bits 0-5, the force bit (15), the channel enables (bits 16-22, channel n at bit 16+n) and the master enable (23) from the write data. Bits 6-14 always read 0.
- R3: A write to any other offset changes nothing. Read data is the word only while the read strobe is high and the offset is 0xF4, and is 0 otherwise.
- R4: A write of 1 to flag bit 24+n clears channel n's flag. A write of 0 there leaves the flag unchanged.
- R5: A done pulse on channel n sets flag 24+n only if enable bit 16+n is set at that cycle. Otherwise the pulse is ignored.
- R6: After each update, bit 31 equals force OR (master enable AND any flag). Writing bit 31 has no direct effect.
- R7: The interrupt pulse is raised for an update whose result sets bit 31 only if bit 31 was 0 before that update. It stays low if bit 31 was already 1.
- R8: When a done pulse and a write-1 clear hit the same enabled flag in the same cycle, the flag ends set.
- R9: The interrupt pulse is a registered output. It appears in the cycle after the clock edge that performs the update and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, 0 unless the control word is read |
| chan_done | input | 7 | Per-channel transfer-complete pulses |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The master-flag logic is driven three ways: by the force bit alone, by done pulses under the master enable, and by setting the master enable after a flag is already pending. This separates the force term from the enabled-flag term and shows that a write recomputes the flag as well as a done pulse. Done pulses are applied to a mix of enabled and disabled channels. A pulse that arrives while the master flag is already set confirms that no second interrupt is raised. A same-cycle clear and set, a write of bit 31, a write to a foreign offset and a write of all ones each isolate one masking rule.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int CTL_W     = 32;
  localparam int LOW_W     = 6;
  localparam int FORCE_BIT = 15;
  localparam int EN_LSB    = 16;
  localparam int MEN_BIT   = 23;
  localparam int FLG_LSB   = 24;
  localparam int MST_BIT   = 31;
  localparam int MAX_CH    = MST_BIT - FLG_LSB;
endpackage

// File: rtl/dic_wr_decode.sv
module dic_wr_decode #(
  parameter int               ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'hF4
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_hit_o,
  output logic              rd_hit_o
);
  logic sel;

  always_comb begin
    sel      = (addr_i == REG_OFS);
    wr_hit_o = wr_i & sel;
    rd_hit_o = rd_i & sel;
  end
endmodule

// File: rtl/dic_flag_cell.sv
module dic_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_d_o,
  output logic flag_q_o
);
  logic upd;

  // a set in the same cycle as a clear takes precedence
  always_comb begin
    upd      = set_i | clr_i;
    flag_d_o = flag_q_o;
    if (upd) flag_d_o = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q_o <= 1'b0;
    else if (upd) flag_q_o <= flag_d_o;
  end
endmodule

// File: rtl/dic_master.sv
module dic_master #(
  parameter int NCH = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           update_i,
  input  logic           force_i,
  input  logic           men_i,
  input  logic [NCH-1:0] flags_i,
  output logic           master_q_o,
  output logic           irq_q_o
);
  logic cond;
  logic master_d;
  logic irq_d;

  always_comb begin
    cond     = force_i | (men_i & (|flags_i));
    master_d = update_i ? cond : master_q_o;
    irq_d    = update_i & cond & ~master_q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q_o <= 1'b0;
      irq_q_o    <= 1'b0;
    end else begin
      irq_q_o <= irq_d;
      if (update_i) master_q_o <= master_d;
    end
  end
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
  import dic_pkg::*;
#(
  parameter int               NCH     = 7,
  parameter int               ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFS = 8'hF4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTL_W-1:0]  reg_wdata,
  output logic [CTL_W-1:0]  reg_rdata,
  input  logic [NCH-1:0]    chan_done,
  output logic              irq_pulse
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic wr_hit;
  logic rd_hit;

  dic_wr_decode #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_dec (
    .wr_i     (reg_wr),
    .rd_i     (reg_rd),
    .addr_i   (reg_addr),
    .wr_hit_o (wr_hit),
    .rd_hit_o (rd_hit)
  );

  // directly writable configuration fields
  logic [LOW_W-1:0] low_q, low_d;
  logic             force_q, force_d;
  logic [NCH-1:0]   en_q, en_d;
  logic             men_q, men_d;

  always_comb begin
    low_d   = low_q;
    force_d = force_q;
    en_d    = en_q;
    men_d   = men_q;
    if (wr_hit) begin
      low_d   = reg_wdata[LOW_W-1:0];
      force_d = reg_wdata[FORCE_BIT];
      en_d    = reg_wdata[EN_LSB +: NCH];
      men_d   = reg_wdata[MEN_BIT];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      low_q   <= '0;
      force_q <= 1'b0;
      en_q    <= '0;
      men_q   <= 1'b0;
    end else if (wr_hit) begin
      low_q   <= low_d;
      force_q <= force_d;
      en_q    <= en_d;
      men_q   <= men_d;
    end
  end

  // per-channel completion flags
  logic [NCH-1:0] flag_d;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] set_vec;

  assign set_vec = chan_done & en_q;

  for (genvar n = 0; n < NCH; n++) begin : g_flag
    dic_flag_cell u_fc (
      .clk      (clk),
      .rst_n    (srst_n),
      .set_i    (set_vec[n]),
      .clr_i    (wr_hit & reg_wdata[FLG_LSB + n]),
      .flag_d_o (flag_d[n]),
      .flag_q_o (flag_q[n])
    );
  end

  logic update;
  logic master_q;

  assign update = wr_hit | (|set_vec);

  dic_master #(.NCH(NCH)) u_mst (
    .clk        (clk),
    .rst_n      (srst_n),
    .update_i   (update),
    .force_i    (force_d),
    .men_i      (men_d),
    .flags_i    (flag_d),
    .master_q_o (master_q),
    .irq_q_o    (irq_pulse)
  );

  // assembled control word
  logic [CTL_W-1:0] ctl_w;

  always_comb begin
    ctl_w                = '0;
    ctl_w[LOW_W-1:0]     = low_q;
    ctl_w[FORCE_BIT]     = force_q;
    ctl_w[EN_LSB +: NCH] = en_q;
    ctl_w[MEN_BIT]       = men_q;
    ctl_w[FLG_LSB +: NCH] = flag_q;
    ctl_w[MST_BIT]       = master_q;
  end

  assign reg_rdata = rd_hit ? ctl_w : '0;

  logic [FORCE_BIT-LOW_W:0] unused_wbits;
  assign unused_wbits = {reg_wdata[FORCE_BIT-1:LOW_W], reg_wdata[MST_BIT]};
endmodule

// File: rtl/dic_chk.sv
module dic_chk
  import dic_pkg::*;
#(
  parameter int NCH = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [CTL_W-1:0] ctl,
  input logic [NCH-1:0]   done
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (ctl == '0) && !irq);

  p_mid_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[FORCE_BIT-1:LOW_W] == '0);

  p_master_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl[MST_BIT] == (ctl[FORCE_BIT] | (ctl[MEN_BIT] & (|ctl[FLG_LSB +: NCH]))));

  p_irq_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl[MST_BIT] && !$past(ctl[MST_BIT]));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl[FLG_LSB + n]) |-> $past(ctl[EN_LSB + n]) && $past(done[n]));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done[n] && ctl[EN_LSB + n]) |=> ctl[FLG_LSB + n]);
  end
endmodule

bind dma_irq_ctl dic_chk #(.NCH(NCH)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .irq  (irq_pulse),
  .ctl  (ctl_w),
  .done (chan_done)
);

// File: tb/sim_dma_irq_ctl.sv
module sim_dma_irq_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [6:0]  chan_done;
  logic        irq_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_irq_ctl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chan_done(chan_done), .irq_pulse(irq_pulse)
  );

  // {req[3:0], wr, addr[7:0], wdata[31:0], done[6:0], exp_word[31:0], exp_irq}
  localparam int NV = 18;
  localparam logic [84:0] VEC [NV] = '{
    {4'd2, 1'b1, 8'hF4, 32'hFFFFFFFF, 7'h00, 32'h80FF803F, 1'b1}, // R2 R6 force
    {4'd6, 1'b1, 8'hF4, 32'h00FF0000, 7'h00, 32'h00FF0000, 1'b0}, // R6 force off
    {4'd7, 1'b0, 8'hF4, 32'h00000000, 7'h01, 32'h81FF0000, 1'b1}, // R7 first flag
    {4'd7, 1'b0, 8'hF4, 32'h00000000, 7'h02, 32'h83FF0000, 1'b0}, // R7 no repeat
    {4'd4, 1'b1, 8'hF4, 32'h01FF0000, 7'h00, 32'h82FF0000, 1'b0}, // R4 clear one
    {4'd4, 1'b1, 8'hF4, 32'h02FF0000, 7'h00, 32'h00FF0000, 1'b0}, // R4 clear last
    {4'd2, 1'b1, 8'hF4, 32'h00010000, 7'h00, 32'h00010000, 1'b0}, // R2
    {4'd5, 1'b0, 8'hF4, 32'h00000000, 7'h7F, 32'h01010000, 1'b0}, // R5 only ch0
    {4'd6, 1'b1, 8'hF4, 32'h00810000, 7'h00, 32'h81810000, 1'b1}, // R6 write recompute
    {4'd6, 1'b1, 8'hF4, 32'h81810000, 7'h00, 32'h00810000, 1'b0}, // R6 bit31 ignored
    {4'd8, 1'b1, 8'hF4, 32'h01810000, 7'h01, 32'h81810000, 1'b1}, // R8 set wins
    {4'd3, 1'b1, 8'hF0, 32'h00000000, 7'h00, 32'h81810000, 1'b0}, // R3 foreign offset
    {4'd6, 1'b1, 8'hF4, 32'h00008000, 7'h00, 32'h81008000, 1'b0}, // R6 R7 held master
    {4'd4, 1'b1, 8'hF4, 32'h01000000, 7'h00, 32'h00000000, 1'b0}, // R4
    {4'd5, 1'b0, 8'hF4, 32'h00000000, 7'h40, 32'h00000000, 1'b0}, // R5 disabled
    {4'd2, 1'b1, 8'hF4, 32'h00407FFF, 7'h00, 32'h0040003F, 1'b0}, // R2 mid bits
    {4'd5, 1'b0, 8'hF4, 32'h00000000, 7'h40, 32'h4040003F, 1'b0}, // R5 ch6
    {4'd7, 1'b1, 8'hF4, 32'h00C0003F, 7'h00, 32'hC0C0003F, 1'b1}  // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic apply(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       input logic [6:0] dn);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; chan_done = dn; reg_rd = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; chan_done = '0;
    reg_rd = 1'b1; reg_addr = 8'hF4;
    #1;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_wdata = '0; chan_done = '0;
    repeat (3) @(negedge clk);
    reg_rd = 1'b1; reg_addr = 8'hF4; #1;
    check("R1 word in reset", reg_rdata, 32'h0);
    check("R1 irq in reset", {31'h0, irq_pulse}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    check("R1 word after release", reg_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][80], VEC[i][79:72], VEC[i][71:40], VEC[i][39:33]);
      check($sformatf("R%0d vec %0d word", VEC[i][84:81], i), reg_rdata, VEC[i][32:1]);
      check($sformatf("R%0d vec %0d irq", VEC[i][84:81], i), {31'h0, irq_pulse},
            {31'h0, VEC[i][0]});
    end

    // R3: read gating
    reg_rd = 1'b0; #1;
    check("R3 no strobe", reg_rdata, 32'h0);
    reg_rd = 1'b1; reg_addr = 8'hF0; #1;
    check("R3 foreign read", reg_rdata, 32'h0);
    reg_addr = 8'hF4; #1;
    check("R3 own read", reg_rdata, 32'hC0C0003F);

    // drop master: clear flag 6
    apply(1'b1, 8'hF4, 32'h40C0003F, 7'h00);
    check("R4 clear ch6", reg_rdata, 32'h00C0003F);

    // R9: pulse timing and width
    @(negedge clk); chan_done = 7'h40; #1;
    check("R9 low before edge", {31'h0, irq_pulse}, 32'h0);
    @(negedge clk); chan_done = 7'h00; #1;
    check("R9 high after edge", {31'h0, irq_pulse}, 32'h1);
    check("R9 word", reg_rdata, 32'hC0C0003F);
    @(negedge clk); #1;
    check("R9 one cycle", {31'h0, irq_pulse}, 32'h0);

    // R1: reset in mid run
    rst_n = 1'b0; #1;
    check("R1 async clear", reg_rdata, 32'h0);
    check("R1 irq clear", {31'h0, irq_pulse}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk); #1;
    check("R1 after re-release", reg_rdata, 32'h0);

    finished = 1'b1;
    summary();
  end
endmodule